// File: doc/BRIEF.md
# Sampling Phase Search Sequencer

This block runs an automatic search over the phase setting of a pixel sampling clock. A start pulse arms it. From the next frame strobe onward, it holds one candidate phase per frame interval. At the strobe that closes each interval, it takes a quality score from an external per-frame accumulator. It keeps the phase index whose score is the extreme so far: the largest score, or the smallest if the worst phase is wanted. When the last interval closes, it raises a one-cycle done pulse and drives the chosen phase.

The sweep has 28 or 64 steps. Its candidates are spread evenly over the 6-bit phase range. A small configuration register sets four things: the search mode, the sweep length, whether phase changes wait for a frame strobe or apply at once, and a soft reset that holds the whole search idle. The accumulator and the analog phase generator sit outside this block.

Top module: `phase_sweep_seq`

## Requirements
- R1: After reset, `phase_out` is 0, `busy` is 0 and `done` is 0. The configuration register holds 4'b0100: the apply-on-strobe bit is set and every other bit is clear.
- R2: A `start` pulse while idle and not held in soft reset raises `busy` on the following cycle. The first `vsync` after that opens the interval for candidate 0. Candidate k uses phase floor(k*63/(N-1)), where N is the step count.
- R3: Configuration bit 1 (long sweep) selects N=28 when 0 and N=64 when 1. Completion comes at the N-th scoring `vsync`, which is the (N+1)-th `vsync` after start.
- R4: Configuration bit 0 (pick worst) selects the largest score when 0 and the smallest when 1. On equal scores the earlier candidate index is kept.
- R5: `done` is high for exactly one cycle, the one after the final scoring `vsync`. In that same cycle `busy` is low and `phase_out` shows the chosen phase.
- R6: With configuration bit 2 (apply on strobe) clear, a new phase target reaches `phase_out` on the same clock edge that sets it, including the return to phase 0 at start.
- R7: With configuration bit 2 set, `phase_out` changes only on an edge where `vsync` is high. The one exception is the soft reset of R8, which clears it.
- R8: While configuration bit 3 (soft reset) is 1, `busy`, `done` and `phase_out` are 0 and `start` and `vsync` have no effect. Clearing the bit restores normal operation.
- R9: A `start` during a search is ignored. The mode and length in use are those captured at start, even if the register changes during the search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration value: bit0 pick worst, bit1 long sweep, bit2 apply on strobe, bit3 soft reset |
| start | input | 1 | Search launch pulse |
| vsync | input | 1 | Frame boundary strobe, one cycle |
| score | input | SCORE_W | Quality score of the interval closing at this strobe |
| phase_out | output | PHASE_W | Sampling phase setting |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a configuration change in the middle of a search: a second start, or a new mode and length, arriving while a sweep is running. The bench writes the opposite mode and length and pulses start a few steps into a sweep, then checks that the sweep still ends after the original step count with the original selection rule. Ties are made common by drawing scores from a narrow random range and by one directed run with all scores equal. The difference between the two apply modes is exposed by restarting after a search that left a nonzero phase.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} psw_state_e;

  typedef struct packed {
    logic hold_rst;
    logic apply_vsync;
    logic long_sweep;
    logic pick_worst;
  } psw_cfg_t;

  localparam logic [3:0] CFG_RESET = 4'b0100;
endpackage

// File: rtl/psw_cfg.sv
module psw_cfg
  import psw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] wdata,
  output psw_cfg_t   cfg
);
  psw_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= psw_cfg_t'(CFG_RESET);
    else if (we) cfg_q <= psw_cfg_t'(wdata);
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/psw_track.sv
module psw_track #(
  parameter int SCORE_W = 16,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               sample,
  input  logic               first,
  input  logic               pick_worst,
  input  logic [SCORE_W-1:0] score,
  input  logic [IDX_W-1:0]   idx,
  output logic               take,
  output logic [IDX_W-1:0]   win_idx
);
  logic [SCORE_W-1:0] ext_q;
  logic [IDX_W-1:0]   ext_idx_q;
  logic               beats;

  // strict comparison keeps the earlier index on a tie
  assign beats   = pick_worst ? (score < ext_q) : (score > ext_q);
  assign take    = sample && (first || beats);
  assign win_idx = take ? idx : ext_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q     <= '0;
      ext_idx_q <= '0;
    end else if (clr) begin
      ext_q     <= '0;
      ext_idx_q <= '0;
    end else if (take) begin
      ext_q     <= score;
      ext_idx_q <= idx;
    end
  end
endmodule

// File: rtl/psw_fsm.sv
module psw_fsm
  import psw_pkg::*;
#(
  parameter int PHASE_W     = 6,
  parameter int SHORT_STEPS = 28,
  parameter int LONG_STEPS  = 64,
  localparam int IDX_W      = (LONG_STEPS > 2) ? $clog2(LONG_STEPS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               start,
  input  logic               vsync,
  input  logic               cfg_long,
  input  logic               cfg_worst,
  input  logic [IDX_W-1:0]   win_idx,
  output logic               start_ok,
  output logic               sample,
  output logic               first,
  output logic               last,
  output logic               worst_q,
  output logic [IDX_W-1:0]   step,
  output logic [PHASE_W-1:0] target_d,
  output logic               busy,
  output logic               done
);
  localparam int PH_MAX = (1 << PHASE_W) - 1;

  // even spread of candidate k over the phase range
  function automatic logic [PHASE_W-1:0] phase_of(input logic [IDX_W-1:0] k, input logic lng);
    int n;
    n = lng ? LONG_STEPS : SHORT_STEPS;
    return PHASE_W'((int'(k) * PH_MAX) / (n - 1));
  endfunction

  psw_state_e         st_q;
  logic [IDX_W-1:0]   step_q;
  logic               lng_q;
  logic               wst_q;
  logic               done_q;
  logic [PHASE_W-1:0] target_q;

  assign start_ok = start && (st_q == ST_IDLE) && !clr;
  assign sample   = vsync && (st_q == ST_RUN);
  assign first    = (step_q == '0);
  assign last     = lng_q ? (step_q == IDX_W'(LONG_STEPS - 1)) : (step_q == IDX_W'(SHORT_STEPS - 1));

  always_comb begin
    target_d = target_q;
    if (start_ok)    target_d = phase_of('0, cfg_long);
    else if (sample) target_d = last ? phase_of(win_idx, lng_q) : phase_of(step_q + IDX_W'(1), lng_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; step_q <= '0; lng_q <= 1'b0; wst_q <= 1'b0;
      done_q <= 1'b0; target_q <= '0;
    end else if (clr) begin
      st_q <= ST_IDLE; step_q <= '0; lng_q <= 1'b0; wst_q <= 1'b0;
      done_q <= 1'b0; target_q <= '0;
    end else begin
      done_q   <= sample && last;
      target_q <= target_d;
      case (st_q)
        ST_IDLE: if (start_ok) begin
          st_q   <= ST_ARM;
          step_q <= '0;
          lng_q  <= cfg_long;
          wst_q  <= cfg_worst;
        end
        ST_ARM: if (vsync) st_q <= ST_RUN;
        ST_RUN: if (sample) begin
          if (last) st_q <= ST_IDLE;
          else      step_q <= step_q + IDX_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign worst_q = wst_q;
  assign step    = step_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/psw_apply.sv
module psw_apply #(
  parameter int PHASE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               apply_vsync,
  input  logic               vsync,
  input  logic [PHASE_W-1:0] target_d,
  output logic [PHASE_W-1:0] phase_out
);
  logic [PHASE_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ph_q <= '0;
    else if (clr)                    ph_q <= '0;
    else if (!apply_vsync || vsync)  ph_q <= target_d;
  end

  assign phase_out = ph_q;
endmodule

// File: rtl/phase_sweep_seq.sv
module phase_sweep_seq
  import psw_pkg::*;
#(
  parameter int PHASE_W     = 6,
  parameter int SCORE_W     = 16,
  parameter int SHORT_STEPS = 28,
  parameter int LONG_STEPS  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_wdata,
  input  logic               start,
  input  logic               vsync,
  input  logic [SCORE_W-1:0] score,
  output logic [PHASE_W-1:0] phase_out,
  output logic               busy,
  output logic               done
);
  localparam int IDX_W = (LONG_STEPS > 2) ? $clog2(LONG_STEPS) : 1;

  psw_cfg_t           cfg_q;
  logic               start_ok, sample, first, last, take, worst_q;
  logic [IDX_W-1:0]   step, win_idx;
  logic [PHASE_W-1:0] target_d;

  psw_cfg u_cfg (.clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg_q));

  psw_fsm #(.PHASE_W(PHASE_W), .SHORT_STEPS(SHORT_STEPS), .LONG_STEPS(LONG_STEPS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clr(cfg_q.hold_rst), .start(start), .vsync(vsync),
    .cfg_long(cfg_q.long_sweep), .cfg_worst(cfg_q.pick_worst), .win_idx(win_idx),
    .start_ok(start_ok), .sample(sample), .first(first), .last(last), .worst_q(worst_q),
    .step(step), .target_d(target_d), .busy(busy), .done(done));

  psw_track #(.SCORE_W(SCORE_W), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(cfg_q.hold_rst), .sample(sample), .first(first),
    .pick_worst(worst_q), .score(score), .idx(step), .take(take), .win_idx(win_idx));

  psw_apply #(.PHASE_W(PHASE_W)) u_apply (
    .clk(clk), .rst_n(rst_n), .clr(cfg_q.hold_rst), .apply_vsync(cfg_q.apply_vsync),
    .vsync(vsync), .target_d(target_d), .phase_out(phase_out));
endmodule

// File: rtl/psw_checker.sv
module psw_checker
  import psw_pkg::*;
#(
  parameter int PHASE_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input psw_cfg_t           cfg,
  input logic               vsync,
  input logic               start_ok,
  input logic               sample,
  input logic               first,
  input logic               last,
  input logic               take,
  input logic [PHASE_W-1:0] phase_out,
  input logic               busy,
  input logic               done
);
  // R2: accepted start leads to a busy search
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);
  // R3: closing the final interval completes the search
  a_r3_last_done: assert property (@(posedge clk) disable iff (!rst_n)
    sample && last && !cfg.hold_rst |=> done);
  // R4: the first score of a sweep always becomes the running extreme
  a_r4_first_taken: assert property (@(posedge clk) disable iff (!rst_n)
    sample && first |-> take);
  // R5: done is a single-cycle pulse with busy already low
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r5_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || $past(cfg.hold_rst)));
  // R7: strobe-synchronous mode holds the phase between strobes
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.apply_vsync && !vsync && !cfg.hold_rst |=> $stable(phase_out));
  // R8: soft reset clears the outputs
  a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.hold_rst |=> (!busy && !done && phase_out == '0));
  // R9: no restart while a search runs
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ok);
endmodule

bind phase_sweep_seq psw_checker #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .vsync(vsync), .start_ok(start_ok),
  .sample(sample), .first(first), .last(last), .take(take),
  .phase_out(phase_out), .busy(busy), .done(done));

// File: tb/sim_phase_sweep_seq.sv
module sim_phase_sweep_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        start = 1'b0;
  logic        vsync = 1'b0;
  logic [15:0] score = '0;
  logic [5:0]  phase_out;
  logic        busy, done;
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  phase_sweep_seq u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start(start), .vsync(vsync), .score(score), .phase_out(phase_out), .busy(busy), .done(done));

  function automatic int exp_ph(int k, int n);
    if (n == 64) return k;
    return (k * 63) / 27;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(bit worst, bit lng, bit vs, bit hold);
    cfg_wdata = {hold, vs, lng, worst};
    cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic vpulse(int s);
    score = 16'(s);
    vsync = 1'b1;
    tick(1);
    vsync = 1'b0;
  endtask

  // pat: 0 narrow random, 1 rising ramp, 2 all equal
  task automatic run_search(bit worst, bit lng, bit vs, bit do_write, int pat, bit swap);
    int n, best_i, best_s, s, prev;
    n = lng ? 64 : 28;
    if (do_write) write_cfg(worst, lng, vs, 1'b0);
    prev = int'(phase_out);
    pulse_start();
    chk("R2", "busy after start", int'(busy), 1);
    if (vs) chk("R7", "phase held until strobe", int'(phase_out), prev);
    else    chk("R6", "phase 0 at once", int'(phase_out), 0);
    tick($urandom_range(0, 2));
    vpulse(int'($urandom_range(0, 50)));
    chk("R2", "candidate 0 phase", int'(phase_out), 0);
    best_i = 0; best_s = 0;
    for (int k = 0; k < n; k++) begin
      tick($urandom_range(0, 3));
      if (swap && k == 5) begin
        write_cfg(~worst, ~lng, vs, 1'b0);
        pulse_start();
        chk("R9", "start ignored while busy", int'(busy), 1);
      end
      case (pat)
        1: s = 100 + k;
        2: s = 7;
        default: s = int'($urandom_range(0, 9));
      endcase
      if (k == 0 || (worst ? s < best_s : s > best_s)) begin best_i = k; best_s = s; end
      vpulse(s);
      if (k < n - 1) begin
        chk("R2", "candidate phase", int'(phase_out), exp_ph(k + 1, n));
        chk("R3", "no early done", int'(done), 0);
      end else begin
        chk("R5", "done pulse", int'(done), 1);
        chk("R5", "busy low at done", int'(busy), 0);
        chk("R4", "chosen phase", int'(phase_out), exp_ph(best_i, n));
      end
    end
    tick(1);
    chk("R5", "done single cycle", int'(done), 0);
    chk("R4", "phase kept", int'(phase_out), exp_ph(best_i, n));
    if (swap) write_cfg(worst, lng, vs, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    chk("R1", "reset phase", int'(phase_out), 0);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset done", int'(done), 0);
    rst_n = 1'b1;
    tick(2);
    // R1: default config is best mode, short sweep, strobe-synchronous
    run_search(1'b0, 1'b0, 1'b1, 1'b0, 1, 1'b0);
    chk("R1", "default picks last of ramp", int'(phase_out), 63);
    // R6: immediate mode drops to 0 at start
    run_search(1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b0);
    run_search(1'b0, 1'b1, 1'b0, 1'b1, 1, 1'b0);
    // R4: ties keep the first candidate
    run_search(1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b0);
    run_search(1'b1, 1'b1, 1'b1, 1'b1, 2, 1'b0);
    // R9: mid-search restart and config change
    run_search(1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b1);
    run_search(1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1);
    // R8: soft reset during a search
    write_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    pulse_start();
    vpulse(5); tick(1); vpulse(9); tick(1); vpulse(3);
    write_cfg(1'b0, 1'b0, 1'b0, 1'b1);
    tick(1);
    chk("R8", "busy cleared", int'(busy), 0);
    chk("R8", "phase cleared", int'(phase_out), 0);
    pulse_start();
    chk("R8", "start ignored in hold", int'(busy), 0);
    vpulse(20);
    chk("R8", "strobe ignored in hold", int'(phase_out), 0);
    chk("R8", "no done in hold", int'(done), 0);
    write_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    run_search(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    // random mix
    for (int r = 0; r < 6; r++)
      run_search(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'b1, int'($urandom_range(0, 2)), 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule